// File: doc/BRIEF.md
# Dual-Oscillator Startup and Low-Power Controller

This block supervises two clock sources: a fast main oscillator that needs time to settle after it starts, and a slow secondary oscillator that runs all the time. It keeps a run-enable bit for the main oscillator and times its settling with a 13-bit counter. The counter is built from a 7-bit low divider and a 6-bit high counter, and it starts from a fixed nonzero preset. When the high counter wraps, a stable flag is raised. Only then may software switch the system clock over to the main oscillator.

The block also sequences the low-power modes. In wait mode it gates the CPU clock and leaves peripheral clocks running. In stop mode it gates both clocks, shuts the main oscillator down and clears the stable flag. Stop mode is left only on a dedicated wake event. On wake the block decides whether the CPU must be held: it is held until the settling count completes when the main oscillator is the selected source, and released at once when the secondary oscillator is selected. After reset the CPU is held until the first settling count has completed.

Top module: `osc_pwr_ctrl`

## Requirements
- R1: During and right after reset, the outputs are as follows: `osc_stable`=0, `osc_run`=1, `clk_sel_main`=0, `cpu_clk_en`=0 and `periph_clk_en`=0. When the first settling count completes, `cpu_clk_en` and `periph_clk_en` rise, and `cpu_resume` is high for exactly one cycle.
- R2: `osc_stable` rises after exactly 8072 `main_tick` cycles. The counter starts from the preset 0x0078 and overflows when it wraps past 0x1FFF. Only ticks that arrive while `osc_run`=1 are counted, so gaps between ticks do not change the total.
- R3: A write of 0 to the enable bit (`en_wr`=1, `en_val`=0) behaves as follows while the secondary source is selected. It drops `osc_run` and clears `osc_stable`. Ticks received while the bit is clear are ignored. After the bit is written to 1 again, a full 8072 ticks are needed. The CPU clock keeps running throughout.
- R4: A request to select the main source (`sel_wr`=1, `sel_val`=1) only takes effect while `osc_stable`=1. Otherwise `clk_sel_main` stays 0. While `clk_sel_main`=1, a write of 0 to the enable bit is ignored and `osc_run` stays 1.
- R5: `wait_req` gives `cpu_clk_en`=0 and `periph_clk_en`=1, and leaves `osc_run` unchanged. Either `irq_any` or any bit of `wake_evt` ends wait mode. On exit `cpu_clk_en` returns to 1 and `cpu_resume` pulses for one cycle.
- R6: `stop_req` gives `cpu_clk_en`=0, `periph_clk_en`=0, `osc_run`=0 and `osc_stable`=0. `irq_any` alone does not end stop mode; only a bit of `wake_evt` does.
- R7: A wake from stop with the secondary source selected sets `cpu_clk_en` in the cycle after the wake. If the enable bit is set, the main oscillator restarts and needs 8072 ticks while the CPU runs.
- R8: A wake from stop with the main source selected holds `cpu_clk_en` at 0 for 8072 ticks. `cpu_clk_en` then rises in the same cycle as `osc_stable`.
- R9: A wake from stop with the enable bit clear leaves `osc_run` at 0.
- R10: When `stop_req` and `wait_req` are both asserted, stop mode is taken, so `periph_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or external) |
| main_tick | input | 1 | One pulse per main-oscillator count |
| en_wr | input | 1 | Write strobe for the main-oscillator enable bit |
| en_val | input | 1 | Value written to the enable bit |
| sel_wr | input | 1 | Write strobe for the clock-source select |
| sel_val | input | 1 | 1 requests the main source, 0 the secondary |
| stop_req | input | 1 | Enter stop mode |
| wait_req | input | 1 | Enter wait mode |
| irq_any | input | 1 | Any interrupt (ends wait mode only) |
| wake_evt | input | 5 | Stop-mode wake sources: two external interrupts, keyboard, serial slave, timebase |
| osc_run | output | 1 | Main oscillator run enable |
| osc_stable | output | 1 | Read-only settled flag |
| clk_sel_main | output | 1 | 1 when the main source is the system clock |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_resume | output | 1 | One-cycle pulse when the CPU restarts |

## Verification
The settling count is measured three ways: with a tick every third cycle after reset, with a tick every cycle after the enable bit is re-set, and with ticks that keep arriving while the bit is clear. The three results show whether the preset is right, whether the counter counts ticks or cycles, and whether it holds while disabled. Stop exits are tried from three starting points: with the main source selected, with the secondary source selected, and with the oscillator disabled. These show whether the CPU is held until overflow, released at once, or left with the oscillator off. Wait mode, and stop requested together with wait, show which clock each mode gates.

// File: rtl/osc_pkg.sv
// Package: shared power-mode encoding for the oscillator controller.
package osc_pkg;
    typedef enum logic [2:0] {
        M_HOLD    = 3'd0,  // after reset, CPU held until first settle
        M_RUN     = 3'd1,
        M_WAIT    = 3'd2,
        M_STOP    = 3'd3,
        M_RECOVER = 3'd4   // leaving stop on main source, awaiting settle
    } pmode_t;
endpackage

// File: rtl/osc_stab_cnt.sv
// Settling timer: a low divider feeding a high counter, both preset to
// PRESET while the oscillator is not running. Counts main ticks until the
// high counter wraps, then raises and holds the stable flag.
// Assumes tick is already synchronous to clk.
module osc_stab_cnt #(
    parameter int DIV_W = 7,
    parameter int HI_W  = 6,
    parameter logic [DIV_W+HI_W-1:0] PRESET = 'h0078
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic stable,
    output logic ovf
);
    localparam int CNT_W = DIV_W + HI_W;

    logic [DIV_W-1:0] div_q;
    logic [HI_W-1:0]  hi_q;
    logic             div_full;

    assign div_full = &div_q;
    assign ovf      = run && !stable && tick && div_full && (&hi_q);

    // Preset while stopped; otherwise advance divider, carry into high part.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q  <= PRESET[DIV_W-1:0];
            hi_q   <= PRESET[CNT_W-1:DIV_W];
            stable <= 1'b0;
        end else if (tick && !stable) begin
            div_q <= div_q + 1'b1;
            if (div_full) hi_q <= hi_q + 1'b1;
            if (ovf) stable <= 1'b1;
        end
    end

    p_ovf_sets_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> stable);
    p_stable_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && run) |=> stable);
    p_off_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!stable && div_q == PRESET[DIV_W-1:0] && hi_q == PRESET[CNT_W-1:DIV_W]));
endmodule

// File: rtl/osc_mode_fsm.sv
// Power-mode sequencer: run, wait, stop, and the two hold states that keep
// the CPU off until the settling counter overflows. Stop wins over wait.
// Assumes requests are single-cycle or level, sampled only in run mode.
module osc_mode_fsm
    import osc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stop_req,
    input  logic   wait_req,
    input  logic   irq_any,
    input  logic   wake_any,
    input  logic   sel_main,
    input  logic   ovf,
    output pmode_t mode,
    output logic   cpu_clk_en,
    output logic   periph_clk_en,
    output logic   cpu_resume
);
    pmode_t nxt;

    // Next-mode decision.
    always_comb begin
        nxt = mode;
        unique case (mode)
            M_HOLD, M_RECOVER: if (ovf) nxt = M_RUN;
            M_RUN: begin
                if (stop_req)      nxt = M_STOP;
                else if (wait_req) nxt = M_WAIT;
            end
            M_WAIT: if (irq_any || wake_any) nxt = M_RUN;
            M_STOP: if (wake_any) nxt = sel_main ? M_RECOVER : M_RUN;
            default: nxt = M_HOLD;
        endcase
    end

    // Mode register and one-cycle resume pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= M_HOLD;
            cpu_resume <= 1'b0;
        end else begin
            mode       <= nxt;
            cpu_resume <= (nxt == M_RUN) && (mode != M_RUN);
        end
    end

    assign cpu_clk_en    = (mode == M_RUN);
    assign periph_clk_en = (mode == M_RUN) || (mode == M_WAIT);

    p_stop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && stop_req) |=> !periph_clk_en);
    p_wait_keeps_periph_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && wait_req && !stop_req) |=> (periph_clk_en && !cpu_clk_en));
    p_main_wake_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STOP && wake_any && sel_main) |=> !cpu_clk_en);
    p_irq_no_stop_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STOP && !wake_any) |=> !cpu_clk_en);
    p_resume_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resume |=> !cpu_resume);
endmodule

// File: rtl/osc_pwr_ctrl.sv
// Top: holds the enable bit and source select, gates the oscillator in
// stop, and joins the settling timer to the mode sequencer.
// Assumes all inputs are synchronous to clk; the select guard and enable
// guard keep the system clock from ever pointing at an unsettled source.
module osc_pwr_ctrl
    import osc_pkg::*;
#(
    parameter int DIV_W  = 7,
    parameter int HI_W   = 6,
    parameter int WAKE_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_tick,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              sel_wr,
    input  logic              sel_val,
    input  logic              stop_req,
    input  logic              wait_req,
    input  logic              irq_any,
    input  logic [WAKE_N-1:0] wake_evt,
    output logic              osc_run,
    output logic              osc_stable,
    output logic              clk_sel_main,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              cpu_resume
);
    localparam logic [DIV_W+HI_W-1:0] PRESET = (DIV_W + HI_W)'(120);

    logic   en_q;
    logic   ovf;
    pmode_t mode;

    assign osc_run = en_q && (mode != M_STOP);

    // Software bits: enable clear refused on main; main select needs stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q         <= 1'b1;
            clk_sel_main <= 1'b0;
        end else begin
            if (en_wr && (en_val || !clk_sel_main)) en_q <= en_val;
            if (sel_wr && (!sel_val || osc_stable)) clk_sel_main <= sel_val;
        end
    end

    osc_stab_cnt #(.DIV_W(DIV_W), .HI_W(HI_W), .PRESET(PRESET)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (osc_run),
        .tick   (main_tick),
        .stable (osc_stable),
        .ovf    (ovf)
    );

    osc_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .wait_req      (wait_req),
        .irq_any       (irq_any),
        .wake_any      (|wake_evt),
        .sel_main      (clk_sel_main),
        .ovf           (ovf),
        .mode          (mode),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .cpu_resume    (cpu_resume)
    );

    p_sel_needs_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && sel_val && !osc_stable && !clk_sel_main) |=> !clk_sel_main);
    p_main_keeps_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_main |=> en_q);
    p_stop_kills_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && stop_req) |=> !osc_run);
    p_disabled_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STOP && !en_q && !en_wr) |=> !osc_run);
endmodule

// File: tb/sim_osc_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_osc_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0;
    logic       en_wr = 1'b0, en_val = 1'b0;
    logic       sel_wr = 1'b0, sel_val = 1'b0;
    logic       stop_req = 1'b0, wait_req = 1'b0, irq_any = 1'b0;
    logic [4:0] wake_evt = 5'b0;
    logic       osc_run, osc_stable, clk_sel_main, cpu_clk_en, periph_clk_en, cpu_resume;

    int errors = 0;
    int checks = 0;
    int tick_mode = 0;  // 0 none, 1 every cycle, 2 every third cycle
    int phase = 0;
    int nt = 0;         // ticks seen while oscillator ran
    bit done = 1'b0;

    always #2 clk = ~clk;

    osc_pwr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .main_tick(main_tick),
        .en_wr(en_wr), .en_val(en_val), .sel_wr(sel_wr), .sel_val(sel_val),
        .stop_req(stop_req), .wait_req(wait_req), .irq_any(irq_any),
        .wake_evt(wake_evt), .osc_run(osc_run), .osc_stable(osc_stable),
        .clk_sel_main(clk_sel_main), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .cpu_resume(cpu_resume)
    );

    always @(negedge clk) begin
        phase = (phase + 1) % 3;
        main_tick = (tick_mode == 1) || (tick_mode == 2 && phase == 0);
    end

    always @(posedge clk) if (main_tick && osc_run) nt++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count ticks until stable; report lowest CPU enable seen and last before.
    task automatic measure(output int n, output int cpu_min, output int cpu_last);
        int base = nt;
        int k = 0;
        cpu_min = 1; cpu_last = cpu_clk_en;
        while (!osc_stable && k < 30000) begin
            cpu_last = cpu_clk_en;
            if (!cpu_clk_en) cpu_min = 0;
            @(negedge clk);
            k++;
        end
        n = nt - base;
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_val = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic v);
        @(negedge clk); sel_wr = 1'b1; sel_val = v;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic pulse_wake(input int b);
        @(negedge clk); wake_evt[b] = 1'b1;
        @(negedge clk); wake_evt = 5'b0;
    endtask

    task automatic t_reset();
        int n, cmin, clast;
        tick_mode = 2;
        cyc(4);
        chk("R1", "stable in reset", osc_stable, 0);
        chk("R1", "run in reset", osc_run, 1);
        chk("R1", "cpu in reset", cpu_clk_en, 0);
        chk("R1", "sel in reset", clk_sel_main, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "periph held", periph_clk_en, 0);
        measure(n, cmin, clast);
        chk("R2", "gapped tick count", n, 8072);
        chk("R1", "cpu held before settle", clast, 0);
        chk("R1", "cpu on at settle", cpu_clk_en, 1);
        chk("R1", "resume pulse", cpu_resume, 1);
        cyc(1);
        chk("R1", "resume one cycle", cpu_resume, 0);
    endtask

    task automatic t_enable_select();
        int n, cmin, clast;
        tick_mode = 1;
        wr_en(1'b0);
        cyc(1);
        chk("R3", "run dropped", osc_run, 0);
        chk("R3", "stable cleared", osc_stable, 0);
        wr_sel(1'b1);
        chk("R4", "select refused", clk_sel_main, 0);
        cyc(50);
        chk("R3", "cpu keeps running", cpu_clk_en, 1);
        wr_en(1'b1);
        measure(n, cmin, clast);
        chk("R3", "full count after re-enable", n, 8072);
        chk("R3", "cpu never gated", cmin, 1);
        wr_sel(1'b1);
        chk("R4", "select accepted", clk_sel_main, 1);
        wr_en(1'b0);
        cyc(1);
        chk("R4", "enable clear ignored", osc_run, 1);
        chk("R4", "still stable", osc_stable, 1);
    endtask

    task automatic t_wait();
        @(negedge clk); wait_req = 1'b1;
        @(negedge clk); wait_req = 1'b0;
        chk("R5", "cpu gated", cpu_clk_en, 0);
        chk("R5", "periph on", periph_clk_en, 1);
        cyc(5);
        chk("R5", "osc unchanged", osc_run, 1);
        @(negedge clk); irq_any = 1'b1;
        @(negedge clk); irq_any = 1'b0;
        chk("R5", "cpu back", cpu_clk_en, 1);
        chk("R5", "resume", cpu_resume, 1);
        cyc(1);
        chk("R5", "resume ends", cpu_resume, 0);
    endtask

    task automatic t_stop_main();
        int n, cmin, clast;
        @(negedge clk); stop_req = 1'b1; wait_req = 1'b1;
        @(negedge clk); stop_req = 1'b0; wait_req = 1'b0;
        chk("R10", "stop wins over wait", periph_clk_en, 0);
        cyc(1);
        chk("R6", "cpu off", cpu_clk_en, 0);
        chk("R6", "osc off", osc_run, 0);
        chk("R6", "stable cleared", osc_stable, 0);
        @(negedge clk); irq_any = 1'b1;
        @(negedge clk); irq_any = 1'b0;
        cyc(1);
        chk("R6", "irq alone no exit", periph_clk_en, 0);
        pulse_wake(2);
        chk("R8", "cpu held on main wake", cpu_clk_en, 0);
        measure(n, cmin, clast);
        chk("R8", "recovery count", n, 8072);
        chk("R8", "cpu held until settle", clast, 0);
        chk("R8", "cpu with stable", cpu_clk_en, 1);
    endtask

    task automatic t_stop_sec();
        int n, cmin, clast;
        wr_sel(1'b0);
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        cyc(3);
        pulse_wake(0);
        chk("R7", "immediate cpu", cpu_clk_en, 1);
        chk("R7", "osc restarted", osc_run, 1);
        measure(n, cmin, clast);
        chk("R7", "restart count", n, 8072);
        chk("R7", "cpu ran during settle", cmin, 1);
    endtask

    task automatic t_stop_off();
        wr_en(1'b0);
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        cyc(3);
        pulse_wake(4);
        chk("R9", "cpu after wake", cpu_clk_en, 1);
        cyc(20);
        chk("R9", "osc stays off", osc_run, 0);
    endtask

    initial begin
        t_reset();
        t_enable_select();
        t_wait();
        t_stop_main();
        t_stop_sec();
        t_stop_off();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule